// File: doc/BRIEF.md
# Stereo Attenuation Control Registers

This block holds the volume settings for a two-channel DAC. A host writes 5-bit fields through an address, data and write-enable interface. Each channel has a 10-bit attenuation code made of a coarse half and a fine half. The fine half counts in 0.125 dB steps and the coarse half counts in 4 dB steps. Every write lands first in a pending (pre-latch) stage.

A write that also carries the commit flag captures all four pending halves as one set. That set becomes the live code at the first audio sample strobe after the commit cycle, so a sample never sees half of an update. A separate mode bit makes the right output follow the left live code. The right channel's own settings are kept while the mode is on and return when it is cleared. Each channel also has a mute flag for the all-ones code.

Top module: `stereo_atten_regs`

## Requirements
- R1: While `rst` is high at a clock edge, both codes go to 0x000 (0 dB) after that edge, both mute flags are low and the follow-left mode is off.
- R2: A write with `wr_addr` 1 or 3 sets the coarse half (code bits [9:5]) of the left or right channel. A write with `wr_addr` 0 or 2 sets the fine half (code bits [4:0]) of the left or right channel. In both cases the field is taken from `wr_data[4:0]`.
- R3: A write with `wr_data[5]` = 0 changes only the pending stage. `left_code` and `right_code` stay unchanged, even across later sample strobes.
- R4: A write to addresses 0 to 3 with `wr_data[5]` = 1 stores its own field and captures all four pending halves, including that field, as the set to apply.
- R5: A captured set reaches `left_code`/`right_code` at the first clock edge after the commit cycle at which `sample_tick` is high. The live codes change at no other edge.
- R6: When a commit write and `sample_tick` fall in the same cycle, the transfer waits for the next `sample_tick`.
- R7: The commit flag is not stored. Writes without it that follow an applied commit are not moved to the outputs by later strobes.
- R8: Bit 2 of a write to address 4 selects follow-left mode. The new mode value takes effect at the next `sample_tick` edge without any commit. While the mode is active, `right_code` equals `left_code`.
- R9: While follow-left mode is active, the right channel's live settings are kept. When the mode is cleared, they appear again from the next `sample_tick`.
- R10: `left_mute`/`right_mute` is high exactly when that channel's output code is 0x3FF. Code 0x3FE (-127.75 dB) is not muted.
- R11: Writes to addresses 5 to 7 have no effect. At address 4, every data bit other than bit 2 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data: [4:0] field, [5] commit, [2] mode at address 4 |
| sample_tick | input | 1 | One-cycle audio sample strobe |
| left_code | output | 10 | Live left attenuation code |
| right_code | output | 10 | Live right attenuation code, after the mode selection |
| left_mute | output | 1 | Left code is 0x3FF |
| right_mute | output | 1 | Right code is 0x3FF |

## Verification
On every cycle, the assertions check that the live codes and the mode move only at sample strobes. They also check that a strobe coinciding with a commit leaves the live codes alone, that a transfer clears the pending state and loads the captured set, and that reset yields 0 dB. Only the bench's scenarios can show the rest, compared against a behavioural model on every clock. That covers the values assembled from split halves, the non-sticky commit, the right settings returning after the follow-left mode, the mute boundary between 0x3FE and 0x3FF, and the ignored addresses.

// File: rtl/atten_pkg.sv
package atten_pkg;
    localparam int HALF_W     = 5;
    localparam int CODE_W     = 2 * HALF_W;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int NUM_CH     = 2;
    localparam int COMMIT_BIT = HALF_W;
    localparam int MODE_ADDR  = 4;
    localparam int MODE_BIT   = 2;
    localparam int FIELD_REGS = 2 * NUM_CH;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {HALF_FINE = 1'b0, HALF_COARSE = 1'b1} half_sel_e;

    typedef struct packed {
        logic [NUM_CH-1:0] fine_we;
        logic [NUM_CH-1:0] coarse_we;
        half_t             field;
        logic              commit;
        logic              mode_we;
        logic              mode_val;
    } wr_cmd_t;

    function automatic code_t merge_half(code_t cur, logic fine_we, logic coarse_we, half_t f);
        code_t r;
        r = cur;
        if (fine_we)   r[HALF_W-1:0]      = f;
        if (coarse_we) r[CODE_W-1:HALF_W] = f;
        return r;
    endfunction

    function automatic logic is_mute(code_t c);
        return c == {CODE_W{1'b1}};
    endfunction
endpackage

// File: rtl/atten_wr_decode.sv
module atten_wr_decode
    import atten_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd
);
    logic      field_hit;
    half_sel_e half_sel;
    logic      ch_sel;

    always_comb begin
        field_hit    = wr_en && (int'(wr_addr) < FIELD_REGS);
        half_sel     = half_sel_e'(wr_addr[0]);
        ch_sel       = wr_addr[1];
        cmd          = '0;
        cmd.field    = wr_data[HALF_W-1:0];
        cmd.commit   = field_hit && wr_data[COMMIT_BIT];
        cmd.mode_we  = wr_en && (int'(wr_addr) == MODE_ADDR);
        cmd.mode_val = wr_data[MODE_BIT];
        for (int c = 0; c < NUM_CH; c++) begin
            cmd.fine_we[c]   = field_hit && (int'(ch_sel) == c) && (half_sel == HALF_FINE);
            cmd.coarse_we[c] = field_hit && (int'(ch_sel) == c) && (half_sel == HALF_COARSE);
        end
    end
endmodule

// File: rtl/atten_chan_stage.sv
module atten_chan_stage
    import atten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fine_we,
    input  logic  coarse_we,
    input  half_t field,
    input  logic  commit,
    input  logic  tick,
    output code_t act_code
);
    code_t pre_q, snap_q, act_q, pre_d;
    logic  pend_q;

    always_comb pre_d = merge_half(pre_q, fine_we, coarse_we, field);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            snap_q <= '0;
            act_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pre_q <= pre_d;
            if (commit) begin
                snap_q <= pre_d;
                pend_q <= 1'b1;
            end else if (tick && pend_q) begin
                act_q  <= snap_q;
                pend_q <= 1'b0;
            end
        end
    end

    assign act_code = act_q;

    assert_quiet_between_ticks_R5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act_q));

    assert_defer_on_clash_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && commit) |=> $stable(act_q));

    assert_transfer_loads_set_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && pend_q && !commit) |=> (!pend_q && act_q == $past(snap_q)));
endmodule

// File: rtl/atten_mode_sel.sv
module atten_mode_sel
    import atten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mode_we,
    input  logic  mode_val,
    input  logic  tick,
    input  code_t left_act,
    input  code_t right_act,
    output code_t left_out,
    output code_t right_out,
    output logic  left_mute,
    output logic  right_mute
);
    logic mode_pre_q, mode_act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_pre_q <= 1'b0;
            mode_act_q <= 1'b0;
        end else begin
            if (mode_we) mode_pre_q <= mode_val;
            if (tick)    mode_act_q <= mode_pre_q;
        end
    end

    always_comb begin
        left_out   = left_act;
        right_out  = mode_act_q ? left_act : right_act;
        left_mute  = is_mute(left_out);
        right_mute = is_mute(right_out);
    end

    assert_mode_moves_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mode_act_q));
endmodule

// File: rtl/stereo_atten_regs.sv
module stereo_atten_regs
    import atten_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sample_tick,
    output logic [CODE_W-1:0] left_code,
    output logic [CODE_W-1:0] right_code,
    output logic              left_mute,
    output logic              right_mute
);
    wr_cmd_t cmd;
    code_t   act [NUM_CH];

    atten_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        atten_chan_stage u_stage (
            .clk       (clk),
            .rst       (rst),
            .fine_we   (cmd.fine_we[c]),
            .coarse_we (cmd.coarse_we[c]),
            .field     (cmd.field),
            .commit    (cmd.commit),
            .tick      (sample_tick),
            .act_code  (act[c])
        );
    end

    atten_mode_sel u_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_we    (cmd.mode_we),
        .mode_val   (cmd.mode_val),
        .tick       (sample_tick),
        .left_act   (act[0]),
        .right_act  (act[1]),
        .left_out   (left_code),
        .right_out  (right_code),
        .left_mute  (left_mute),
        .right_mute (right_mute)
    );

    assert_reset_zero_dB_R1: assert property (@(posedge clk)
        rst |=> (left_code == '0 && right_code == '0 && !left_mute && !right_mute));
endmodule

// File: tb/stereo_atten_regs_test.sv
module stereo_atten_regs_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sample_tick = 1'b0;
    logic [9:0] left_code, right_code;
    logic       left_mute, right_mute;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    stereo_atten_regs uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sample_tick(sample_tick), .left_code(left_code), .right_code(right_code),
        .left_mute(left_mute), .right_mute(right_mute)
    );

    // behavioural reference model
    int  m_pre [4];
    int  m_snap [4];
    bit  m_pend, m_mode_pre, m_mode_act;
    int  m_act [4];

    function automatic int exp_left();
        return m_act[1] * 32 + m_act[0];
    endfunction
    function automatic int exp_right();
        return m_mode_act ? exp_left() : (m_act[3] * 32 + m_act[2]);
    endfunction

    always @(posedge clk) begin
        bit committed;
        bit old_mode;
        committed = 1'b0;
        old_mode  = m_mode_pre;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_pre[i] = 0; m_snap[i] = 0; m_act[i] = 0;
            end
            m_pend = 0; m_mode_pre = 0; m_mode_act = 0;
        end else begin
            if (wr_en && wr_addr < 3'd4) begin
                m_pre[wr_addr] = int'(wr_data[4:0]);
                if (wr_data[5]) begin
                    for (int i = 0; i < 4; i++) m_snap[i] = m_pre[i];
                    m_pend = 1; committed = 1'b1;
                end
            end
            if (wr_en && wr_addr == 3'd4) m_mode_pre = wr_data[2];
            if (sample_tick) begin
                m_mode_act = old_mode;
                if (m_pend && !committed) begin
                    for (int i = 0; i < 4; i++) m_act[i] = m_snap[i];
                    m_pend = 0;
                end
            end
        end
    end

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %h expected %h", req, what, got, exp);
        end
    endtask

    // per-cycle comparison against the model (R2, R5, R10)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R5", "left_code vs model", int'(left_code), exp_left());
            chk("R8", "right_code vs model", int'(right_code), exp_right());
            chk("R10", "left_mute vs model", int'(left_mute), int'(exp_left() == 'h3FF));
            chk("R10", "right_mute vs model", int'(right_mute), int'(exp_right() == 'h3FF));
        end
    end

    task automatic step(bit we, int a, int d, bit tk);
        wr_en = we; wr_addr = 3'(a); wr_data = 8'(d); sample_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; sample_tick = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset left", int'(left_code), 0);
        chk("R1", "reset right", int'(right_code), 0);
        chk("R1", "reset mutes", int'({left_mute, right_mute}), 0);

        // R3: pending writes only
        step(1, 0, 'h05, 0);
        step(1, 1, 'h03, 0);
        step(0, 0, 0, 1);
        chk("R3", "left unchanged without commit", int'(left_code), 0);

        // R4/R2: commit on right coarse captures all halves
        step(1, 2, 'h01, 0);
        step(1, 3, 'h22, 0);
        step(0, 0, 0, 0);
        chk("R5", "no change before tick", int'(left_code), 0);
        step(0, 0, 0, 1);
        chk("R2", "left assembled", int'(left_code), 'h065);
        chk("R4", "right assembled", int'(right_code), 'h041);

        // R7: non-sticky commit
        step(1, 0, 'h07, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        chk("R7", "later write not applied", int'(left_code), 'h065);

        // R6: commit coinciding with tick
        step(1, 1, 'h21, 1);
        chk("R6", "deferred on clash", int'(left_code), 'h065);
        step(0, 0, 0, 1);
        chk("R6", "applied at next tick", int'(left_code), 'h027);

        // R10: mute boundary
        step(1, 0, 'h1F, 0);
        step(1, 1, 'h3F, 0);
        step(0, 0, 0, 1);
        chk("R10", "left 3FF", int'(left_code), 'h3FF);
        chk("R10", "left muted", int'(left_mute), 1);
        step(1, 0, 'h3E, 0);
        step(0, 0, 0, 1);
        chk("R10", "left 3FE", int'(left_code), 'h3FE);
        chk("R10", "3FE not muted", int'(left_mute), 0);

        // R8: follow-left mode
        step(1, 4, 'h04, 0);
        chk("R8", "mode waits for tick", int'(right_code), 'h041);
        step(0, 0, 0, 1);
        chk("R8", "right follows left", int'(right_code), 'h3FE);

        // R11: ignored addresses and bits
        step(1, 5, 'h3F, 0);
        step(1, 6, 'h3F, 0);
        step(1, 7, 'h3F, 0);
        step(1, 4, 'h3F, 0);
        step(0, 0, 0, 1);
        chk("R11", "left after ignored writes", int'(left_code), 'h3FE);
        chk("R11", "mode kept, right", int'(right_code), 'h3FE);

        // R9: right settings return
        step(1, 4, 'h00, 0);
        step(0, 0, 0, 1);
        chk("R9", "right restored", int'(right_code), 'h041);
        chk("R9", "right not muted", int'(right_mute), 0);

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "reset again left", int'(left_code), 0);
        chk("R1", "reset again right", int'(right_code), 0);
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule